// File: doc/BRIEF.md
# Display Self-Test Sequencer

This block runs the self-test of an eight-digit dot-matrix display controller. A start pulse arrives when software writes the self-test bit of the control word. The sequencer then reads every row of every glyph in the font lookup and adds the five-bit row values into a 16-bit checksum. At the end of that window it compares the sum with a parameter.

Next it drives a checkerboard onto all LEDs through an override path into the refresh engine, then the inverse checkerboard. When the fixed-length run ends, it pulses a set of strobes for one cycle. These strobes blank the character memory, clear the flash attributes, load the UDC address register with all ones and write the control word with only the verdict bit kept. A busy flag covers the whole run, and host writes are dropped while it is high.

With the default parameters the run is 32768 checksum cycles plus two pattern windows of 114688 cycles each, or 262144 cycles in total.

Top module: `stest_seq`

## Requirements
- R1: A start pulse taken while idle raises busy_o from the next cycle. busy_o stays high for exactly SUM_LEN + 2*PAT_LEN cycles.
- R2: A start pulse while busy_o is high is ignored, and the run length does not change.
- R3: Font lookups use a valid/ready request. Only one lookup is outstanding at a time. A stalled request keeps valid, code and row unchanged. Requests are made only during the checksum window. They walk code 0..NUM_CODES-1 in the outer loop and row 0..NUM_ROWS-1 in the inner loop, so the run makes exactly NUM_CODES*NUM_ROWS requests.
- R4: The verdict is 1 only when all lookups have returned inside the checksum window and their 16-bit wrapping sum equals EXP_SUM. Any other outcome gives a verdict of 0.
- R5: A response that arrives after the checksum window has closed is discarded. An incomplete walk gives a verdict of 0.
- R6: ovr_en_o is high only in the two pattern windows, which follow the checksum window back to back. The first window shows the checkerboard and the second shows its inverse.
- R7: Bit c of ovr_dots_o is column c of the scanned row. In the first pattern that bit is lit when scan_digit_i + scan_row_i + c is even. The second pattern lights exactly the other dots. ovr_dots_o is 0 whenever the override is off.
- R8: In the cycle when busy_o falls, wipe_o, udc_fill_o and ctrl_wr_o pulse together for one cycle. ctrl_wdata_o is then 8'h20 on a pass and 8'h00 on a fail, because bit 5 carries the verdict.
- R9: host_wr_o follows host_wr_i while idle and is 0 while busy_o is high.
- R10: After reset busy_o, font_req_valid_o, ovr_en_o, all strobes and ovr_dots_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low reset |
| start_i | input | 1 | Self-test start pulse |
| font_req_valid_o | output | 1 | Font lookup request valid |
| font_req_ready_i | input | 1 | Font lookup accepts the request |
| font_code_o | output | CODE_W | Glyph code requested |
| font_row_o | output | ROW_W | Glyph row requested |
| font_rsp_valid_i | input | 1 | Lookup response valid |
| font_rsp_data_i | input | NUM_COLS | Row dot data |
| scan_digit_i | input | DIG_W | Digit being refreshed |
| scan_row_i | input | ROW_W | Row being refreshed |
| ovr_en_o | output | 1 | Refresh engine uses ovr_dots_o |
| ovr_dots_o | output | NUM_COLS | Override dots for the scanned row |
| wipe_o | output | 1 | Blank characters and clear flash bits |
| udc_fill_o | output | 1 | Load UDC address register with ones |
| ctrl_wr_o | output | 1 | Control word load strobe |
| ctrl_wdata_o | output | 8 | Control word value to load |
| host_wr_i | input | 1 | Host write request |
| host_wr_o | output | 1 | Host write passed on to the registers |
| busy_o | output | 1 | Self-test running |

## Verification
The hardest case to reach is a lookup response that arrives after the checksum window has shut while a request is still outstanding. The bench gets there by giving its font model a long response latency and throttling ready, so the walk cannot finish in time and a reply is still in flight when the window closes. The bench also sends a second start pulse in the middle of a run, while lookups are still stalling. This checks that the run length stays fixed. Pattern checks step through a table of scan coordinates in both pattern windows.

// File: rtl/stest_pkg.sv
package stest_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SUM   = 2'd1,
    PH_PAT_A = 2'd2,
    PH_PAT_B = 2'd3
  } stest_phase_e;

  localparam int unsigned CTRL_W       = 8;
  localparam int unsigned VERDICT_BIT  = 5;
  localparam int unsigned SUM_W        = 16;
endpackage

// File: rtl/stest_timer.sv
module stest_timer
  import stest_pkg::*;
#(
  parameter int unsigned SUM_LEN = 32768,
  parameter int unsigned PAT_LEN = 114688
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  output logic         start_ok_o,
  output logic         busy_o,
  output logic         sum_last_o,
  output logic         done_o,
  output stest_phase_e phase_o
);
  localparam int unsigned TOTAL = SUM_LEN + 2 * PAT_LEN;
  localparam int unsigned CW    = $clog2(TOTAL);
  localparam logic [CW-1:0] LAST     = CW'(TOTAL - 1);
  localparam logic [CW-1:0] SUM_LAST = CW'(SUM_LEN - 1);
  localparam logic [CW-1:0] A_START  = CW'(SUM_LEN);
  localparam logic [CW-1:0] B_START  = CW'(SUM_LEN + PAT_LEN);

  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          done_q;

  assign start_ok_o = start_i && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= run_q && (cnt_q == LAST);
      if (start_ok_o) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q) begin
        if (cnt_q == LAST) begin
          run_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (!run_q)              phase_o = PH_IDLE;
    else if (cnt_q < A_START) phase_o = PH_SUM;
    else if (cnt_q < B_START) phase_o = PH_PAT_A;
    else                      phase_o = PH_PAT_B;
  end

  assign busy_o     = run_q;
  assign sum_last_o = run_q && (cnt_q == SUM_LAST);
  assign done_o     = done_q;
endmodule

// File: rtl/stest_csum.sv
module stest_csum
  import stest_pkg::*;
#(
  parameter int unsigned NUM_CODES = 128,
  parameter int unsigned NUM_ROWS  = 7,
  parameter int unsigned NUM_COLS  = 5,
  parameter logic [SUM_W-1:0] EXP_SUM = '0,
  localparam int unsigned CODE_W = $clog2(NUM_CODES),
  localparam int unsigned ROW_W  = $clog2(NUM_ROWS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                active_i,
  input  logic                close_i,
  output logic                req_valid_o,
  input  logic                req_ready_i,
  output logic [CODE_W-1:0]   code_o,
  output logic [ROW_W-1:0]    row_o,
  input  logic                rsp_valid_i,
  input  logic [NUM_COLS-1:0] rsp_data_i,
  output logic                pass_o
);
  localparam int unsigned LOOKUPS = NUM_CODES * NUM_ROWS;
  localparam int unsigned LK_W    = $clog2(LOOKUPS + 1);
  localparam logic [CODE_W-1:0] CODE_LAST = CODE_W'(NUM_CODES - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(NUM_ROWS - 1);

  logic [CODE_W-1:0] code_q;
  logic [ROW_W-1:0]  row_q;
  logic              issued_all_q;
  logic              waiting_q;
  logic [SUM_W-1:0]  sum_q, sum_nxt;
  logic [LK_W-1:0]   rcvd_q, rcvd_nxt;
  logic              pass_q;
  logic              fire, take;

  assign req_valid_o = active_i && !waiting_q && !issued_all_q;
  assign fire        = req_valid_o && req_ready_i;
  assign take        = active_i && waiting_q && rsp_valid_i;
  assign sum_nxt     = take ? sum_q + SUM_W'(rsp_data_i) : sum_q;
  assign rcvd_nxt    = take ? rcvd_q + 1'b1 : rcvd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q       <= '0;
      row_q        <= '0;
      issued_all_q <= 1'b0;
      waiting_q    <= 1'b0;
      sum_q        <= '0;
      rcvd_q       <= '0;
      pass_q       <= 1'b0;
    end else if (clear_i) begin
      code_q       <= '0;
      row_q        <= '0;
      issued_all_q <= 1'b0;
      waiting_q    <= 1'b0;
      sum_q        <= '0;
      rcvd_q       <= '0;
    end else begin
      if (fire) begin
        waiting_q <= 1'b1;
        if (row_q == ROW_LAST) begin
          row_q <= '0;
          if (code_q == CODE_LAST) issued_all_q <= 1'b1;
          else                     code_q <= code_q + 1'b1;
        end else begin
          row_q <= row_q + 1'b1;
        end
      end else if (take) begin
        waiting_q <= 1'b0;
      end
      sum_q  <= sum_nxt;
      rcvd_q <= rcvd_nxt;
      if (close_i) pass_q <= (rcvd_nxt == LK_W'(LOOKUPS)) && (sum_nxt == EXP_SUM);
    end
  end

  assign code_o = code_q;
  assign row_o  = row_q;
  assign pass_o = pass_q;
endmodule

// File: rtl/stest_pattern.sv
module stest_pattern #(
  parameter int unsigned DIG_W    = 3,
  parameter int unsigned ROW_W    = 3,
  parameter int unsigned NUM_COLS = 5
) (
  input  logic                en_i,
  input  logic                inv_i,
  input  logic [DIG_W-1:0]    digit_i,
  input  logic [ROW_W-1:0]    row_i,
  output logic [NUM_COLS-1:0] dots_o
);
  logic base_odd;
  assign base_odd = digit_i[0] ^ row_i[0];

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    localparam logic COL_ODD = 1'((c % 2) == 1);
    assign dots_o[c] = en_i && ((base_odd ^ COL_ODD) ^ ~inv_i);
  end
endmodule

// File: rtl/stest_seq.sv
module stest_seq
  import stest_pkg::*;
#(
  parameter int unsigned NUM_CODES  = 128,
  parameter int unsigned NUM_ROWS   = 7,
  parameter int unsigned NUM_COLS   = 5,
  parameter int unsigned NUM_DIGITS = 8,
  parameter int unsigned SUM_LEN    = 32768,
  parameter int unsigned PAT_LEN    = 114688,
  parameter logic [SUM_W-1:0] EXP_SUM = 16'h0000,
  localparam int unsigned CODE_W = $clog2(NUM_CODES),
  localparam int unsigned ROW_W  = $clog2(NUM_ROWS),
  localparam int unsigned DIG_W  = $clog2(NUM_DIGITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  output logic                font_req_valid_o,
  input  logic                font_req_ready_i,
  output logic [CODE_W-1:0]   font_code_o,
  output logic [ROW_W-1:0]    font_row_o,
  input  logic                font_rsp_valid_i,
  input  logic [NUM_COLS-1:0] font_rsp_data_i,
  input  logic [DIG_W-1:0]    scan_digit_i,
  input  logic [ROW_W-1:0]    scan_row_i,
  output logic                ovr_en_o,
  output logic [NUM_COLS-1:0] ovr_dots_o,
  output logic                wipe_o,
  output logic                udc_fill_o,
  output logic                ctrl_wr_o,
  output logic [CTRL_W-1:0]   ctrl_wdata_o,
  input  logic                host_wr_i,
  output logic                host_wr_o,
  output logic                busy_o
);
  stest_phase_e phase;
  logic start_ok, sum_last, done, pass;

  stest_timer #(.SUM_LEN(SUM_LEN), .PAT_LEN(PAT_LEN)) timer_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .start_ok_o (start_ok),
    .busy_o     (busy_o),
    .sum_last_o (sum_last),
    .done_o     (done),
    .phase_o    (phase)
  );

  stest_csum #(
    .NUM_CODES(NUM_CODES), .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .EXP_SUM(EXP_SUM)
  ) csum_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (start_ok),
    .active_i    (phase == PH_SUM),
    .close_i     (sum_last),
    .req_valid_o (font_req_valid_o),
    .req_ready_i (font_req_ready_i),
    .code_o      (font_code_o),
    .row_o       (font_row_o),
    .rsp_valid_i (font_rsp_valid_i),
    .rsp_data_i  (font_rsp_data_i),
    .pass_o      (pass)
  );

  assign ovr_en_o = (phase == PH_PAT_A) || (phase == PH_PAT_B);

  stest_pattern #(.DIG_W(DIG_W), .ROW_W(ROW_W), .NUM_COLS(NUM_COLS)) pat_i (
    .en_i    (ovr_en_o),
    .inv_i   (phase == PH_PAT_B),
    .digit_i (scan_digit_i),
    .row_i   (scan_row_i),
    .dots_o  (ovr_dots_o)
  );

  always_comb begin
    ctrl_wdata_o = '0;
    ctrl_wdata_o[VERDICT_BIT] = done && pass;
  end

  assign wipe_o     = done;
  assign udc_fill_o = done;
  assign ctrl_wr_o  = done;
  assign host_wr_o  = host_wr_i && !busy_o;
endmodule

// File: rtl/stest_seq_chk.sv
module stest_seq_chk #(
  parameter int unsigned NUM_CODES  = 128,
  parameter int unsigned NUM_ROWS   = 7,
  parameter int unsigned NUM_COLS   = 5,
  parameter int unsigned NUM_DIGITS = 8,
  parameter int unsigned SUM_LEN    = 32768,
  parameter int unsigned PAT_LEN    = 114688,
  localparam int unsigned CODE_W = $clog2(NUM_CODES),
  localparam int unsigned ROW_W  = $clog2(NUM_ROWS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                font_req_valid_o,
  input logic                font_req_ready_i,
  input logic [CODE_W-1:0]   font_code_o,
  input logic [ROW_W-1:0]    font_row_o,
  input logic                ovr_en_o,
  input logic [NUM_COLS-1:0] ovr_dots_o,
  input logic                wipe_o,
  input logic                udc_fill_o,
  input logic                ctrl_wr_o,
  input logic [7:0]          ctrl_wdata_o,
  input logic                host_wr_o,
  input logic                busy_o
);
  localparam int unsigned TOTAL = SUM_LEN + 2 * PAT_LEN;
  logic busy_d;
  int unsigned run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_d  <= 1'b0;
      run_len <= 0;
    end else begin
      busy_d <= busy_o;
      if (busy_o && !busy_d) run_len <= 1;
      else if (busy_o)       run_len <= run_len + 1;
    end
  end

  p_run_length_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_o |-> run_len == TOTAL);
  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    font_req_valid_o && !font_req_ready_i |=>
      font_req_valid_o && $stable(font_code_o) && $stable(font_row_o));
  p_req_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    font_req_valid_o |-> busy_o && !ovr_en_o);
  p_ovr_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_en_o |-> busy_o);
  p_dots_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovr_en_o |-> ovr_dots_o == '0);
  p_end_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_d && !busy_o |-> ctrl_wr_o && wipe_o && udc_fill_o);
  p_strobe_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_o |=> !wipe_o && !udc_fill_o && !ctrl_wr_o);
  p_ctrl_fmt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_o |-> (ctrl_wdata_o & 8'hDF) == 8'h00);
  p_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !host_wr_o);
endmodule

bind stest_seq stest_seq_chk #(
  .NUM_CODES(NUM_CODES), .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS),
  .NUM_DIGITS(NUM_DIGITS), .SUM_LEN(SUM_LEN), .PAT_LEN(PAT_LEN)
) chk_i (.*);

// File: tb/stest_seq_tb_top.sv
module stest_seq_tb_top;
  localparam int unsigned TB_CODES = 4;
  localparam int unsigned TB_ROWS  = 7;
  localparam int unsigned TB_SUM   = 160;
  localparam int unsigned TB_PAT   = 20;
  localparam int unsigned TB_TOTAL = TB_SUM + 2 * TB_PAT;

  function automatic logic [4:0] font_val(input int c, input int r);
    return 5'((c * 7 + r * 3 + 1) % 32);
  endfunction

  function automatic logic [15:0] model_sum();
    logic [15:0] s = '0;
    for (int c = 0; c < TB_CODES; c++)
      for (int r = 0; r < TB_ROWS; r++) s = s + 16'(font_val(c, r));
    return s;
  endfunction

  localparam logic [15:0] TB_EXP = model_sum();

  // {digit, row, dots in the plain checkerboard}
  localparam int unsigned NTAB = 6;
  localparam logic [10:0] PAT_TAB [NTAB] = '{
    {3'd0, 3'd0, 5'b10101}, {3'd0, 3'd1, 5'b01010}, {3'd3, 3'd2, 5'b01010},
    {3'd7, 3'd6, 5'b01010}, {3'd2, 3'd4, 5'b10101}, {3'd5, 3'd5, 5'b10101}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, req_valid, req_ready = 1'b0, rsp_valid = 1'b0;
  logic [1:0] code; logic [2:0] row; logic [4:0] rsp_data = '0;
  logic [2:0] scan_digit = '0, scan_row = '0;
  logic ovr_en, wipe, udc_fill, ctrl_wr, host_wr_in = 1'b0, host_wr_out, busy;
  logic [4:0] dots; logic [7:0] ctrl_wdata;

  int n_checks = 0, n_fail = 0;
  int lat = 1; bit bad = 1'b0;
  int fires = 0, req_err = 0, pend = 0, rtick = 0;
  int pend_code = 0, pend_row = 0;
  bit prev_stall = 1'b0; logic [1:0] prev_code = '0; logic [2:0] prev_row = '0;

  always #2 clk = ~clk;

  stest_seq #(
    .NUM_CODES(TB_CODES), .NUM_ROWS(TB_ROWS), .NUM_COLS(5), .NUM_DIGITS(8),
    .SUM_LEN(TB_SUM), .PAT_LEN(TB_PAT), .EXP_SUM(TB_EXP)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .font_req_valid_o(req_valid), .font_req_ready_i(req_ready),
    .font_code_o(code), .font_row_o(row),
    .font_rsp_valid_i(rsp_valid), .font_rsp_data_i(rsp_data),
    .scan_digit_i(scan_digit), .scan_row_i(scan_row),
    .ovr_en_o(ovr_en), .ovr_dots_o(dots),
    .wipe_o(wipe), .udc_fill_o(udc_fill), .ctrl_wr_o(ctrl_wr), .ctrl_wdata_o(ctrl_wdata),
    .host_wr_i(host_wr_in), .host_wr_o(host_wr_out), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  // font lookup model: ready throttled, response after lat cycles
  initial begin
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = font_val(pend_code, pend_row) ^ 5'((bad && pend_code == 2 && pend_row == 3) ? 1 : 0);
        end
      end
      rtick++;
      req_ready = (rtick % 3) != 0;
      if (prev_stall && !(req_valid && code == prev_code && row == prev_row)) req_err++;
      if (req_valid && req_ready) begin
        if (int'(code) != fires / TB_ROWS || int'(row) != fires % TB_ROWS) req_err++;
        fires++;
        pend_code = int'(code); pend_row = int'(row); pend = lat;
      end
      prev_stall = req_valid && !req_ready;
      prev_code = code; prev_row = row;
    end
  end

  task automatic run_test(input int l, input bit b, input int restart_at,
                          input logic [7:0] exp_ctrl, input string req_v, input bit chk_walk);
    int n = 0, ph_err = 0, dot_err = 0, gate_err = 0;
    lat = l; bad = b; fires = 0; req_err = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    host_wr_in = 1'b1;
    while (busy && n < 1000) begin
      logic [10:0] e;
      e = PAT_TAB[n % NTAB];
      scan_digit = e[10:8]; scan_row = e[7:5];
      start = (n == restart_at);
      #1;
      if (host_wr_out !== 1'b0) gate_err++;
      if (ovr_en !== (n >= int'(TB_SUM))) ph_err++;
      if (n >= int'(TB_SUM) + int'(TB_PAT)) begin
        if (dots !== ~e[4:0]) dot_err++;
      end else if (n >= int'(TB_SUM)) begin
        if (dots !== e[4:0]) dot_err++;
      end else if (dots !== 5'b0) dot_err++;
      n++;
      @(negedge clk);
    end
    start = 1'b0; host_wr_in = 1'b0;
    #1;
    check(n == int'(TB_TOTAL), restart_at >= 0 ? "R2 run length with restart" : "R1 run length", n, TB_TOTAL);
    check(ph_err == 0, "R6 override window", ph_err, 0);
    check(dot_err == 0, "R7 pattern dots", dot_err, 0);
    check(gate_err == 0, "R9 writes dropped while busy", gate_err, 0);
    check(wipe && udc_fill && ctrl_wr, "R8 end strobes", {wipe, udc_fill, ctrl_wr}, 7);
    check(ctrl_wdata == exp_ctrl, req_v, ctrl_wdata, exp_ctrl);
    if (chk_walk) begin
      check(fires == int'(TB_CODES * TB_ROWS), "R3 lookup count", fires, TB_CODES * TB_ROWS);
      check(req_err == 0, "R3 lookup order and hold", req_err, 0);
    end
    @(negedge clk); #1;
    check(!wipe && !ctrl_wr && !udc_fill && !busy, "R8 strobe single cycle", {wipe, ctrl_wr}, 0);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    #(4 * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !req_valid && !ovr_en && !wipe && !ctrl_wr && !udc_fill && dots == 5'b0,
          "R10 reset state", {busy, req_valid, ovr_en, wipe}, 0);
    rst_n = 1'b1;
    @(negedge clk); host_wr_in = 1'b1; #1;
    check(host_wr_out == 1'b1, "R9 write passes when idle", host_wr_out, 1);
    host_wr_in = 1'b0;
    repeat (2) @(negedge clk);
    run_test(1, 1'b0, -1, 8'h20, "R4 verdict pass", 1'b1);
    run_test(2, 1'b0, 30, 8'h20, "R4 verdict pass after restart pulse", 1'b1);
    run_test(1, 1'b1, -1, 8'h00, "R4 verdict fail on bad sum", 1'b1);
    run_test(8, 1'b0, -1, 8'h00, "R5 verdict fail on late responses", 1'b0);
    @(negedge clk); #1;
    check(!busy && dots == 5'b0, "R10 idle after runs", busy, 0);
    report();
  end
endmodule